// File: doc/BRIEF.md
# Fractional Serial Baud Rate Generator

This block derives the timing ticks of one serial channel from a set of four prescaled tick inputs. A select field picks one of the four taps, and an integer divider counts a chosen number of selected taps per output period. When the fraction is switched on, some output periods are stretched by one extra tap. Over every run of 16 output periods exactly (16−K) of them are stretched, so the average divisor becomes N + (16−K)/16. A 4-bit phase accumulator spreads the stretched periods evenly instead of bunching them together.

In UART mode each generator output is offered as a 16x oversampling tick, and every sixteenth of them is also flagged as a bit tick. In synchronous mode the oversampling and bit ticks stay low and a shift clock flips on each generator output, so one shift-clock period spans two generator periods. A one-cycle configuration strobe, raised whenever software writes any divider field, restarts the tap count, the fractional phase, the oversampling count and the shift clock.

The divider is a two-state machine. In state S_COUNT it counts selected taps. When the count reaches N−1 and a tap arrives, the transition "period end" either goes back to S_COUNT with an output pulse, or, when the phase accumulator carries, takes the transition "stretch" into S_EXTRA. In S_EXTRA the next tap takes the transition "extra done" back to S_COUNT with an output pulse. The configuration strobe takes the transition "restart" from either state to S_COUNT.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, tick16, bit_tick and sclk are all 0, and the fraction is disabled by default.
- R2: tap_sel value s (0 to 3) makes the divider count only pulses of tap_in[s]; the other taps have no effect.
- R3: With the fraction off, a generator output is produced once every N selected taps, where N = div_int and div_int = 0 means 16.
- R4: With frac_en = 1 and div_int not equal to 1, any 16 consecutive output periods after a restart span 16·N + (16−K) selected taps, K = frac_k; K = 0 stretches every period to N+1.
- R5: Period p (counting from 0 after a restart) is stretched exactly when acc_p + (16−K) ≥ 16, where acc_0 = 0 and acc_(p+1) = (acc_p + 16 − K) mod 16; for K = 8 the periods alternate N, N+1, starting with N.
- R6: With div_int = 1 the fraction is ignored and the output comes on every selected tap.
- R7: With frac_en = 0 the value of frac_k has no effect on the period.
- R8: With sync_mode = 0, tick16 pulses on every generator output, and bit_tick pulses together with tick16 on the 16th, 32nd, ... output after a restart.
- R9: With sync_mode = 1, tick16 and bit_tick stay 0 and sclk flips one cycle after each generator output.
- R10: cfg_wr high for a cycle clears the tap count, the fractional phase, the oversampling count and sclk; it wins over a period end falling in the same cycle, so no output follows, and the next one comes a full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_in | input | 4 | Prescaler tick pulses, one per tap, one cycle wide |
| tap_sel | input | 2 | Selects which tap_in bit is counted |
| div_int | input | 4 | Integer divisor N, 0 meaning 16 |
| frac_k | input | 4 | Fraction field K, added term is (16−K)/16 |
| frac_en | input | 1 | Enables the fractional term |
| sync_mode | input | 1 | 1 selects the synchronous shift clock, 0 selects UART ticks |
| cfg_wr | input | 1 | Pulse when any divider field is written, restarts the divider |
| tick16 | output | 1 | 16x oversampling tick in UART mode |
| bit_tick | output | 1 | Bit-rate tick in UART mode, every 16th tick16 |
| sclk | output | 1 | Synchronous shift clock |

## Verification
The restart strobe and a period end can land in the same cycle, and the restart must win. The bench provokes this by restarting at N = 3 with a tap on every cycle, then raising cfg_wr again exactly on the third tap, where an output would otherwise be produced. It judges the outcome by requiring tick16 to stay low in the following cycle and the next tick to appear a full three taps later, which also shows that the count was really cleared rather than merely masked.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        S_COUNT = 1'b0,
        S_EXTRA = 1'b1
    } div_state_t;
endpackage

// File: rtl/baud_tap_sel.sv
module baud_tap_sel #(
    parameter int SEL_W = 2
) (
    input  logic [(1<<SEL_W)-1:0] tap_in,
    input  logic [SEL_W-1:0]      tap_sel,
    output logic                  hit
);
    localparam int NTAP = 1 << SEL_W;

    logic [NTAP-1:0] gated;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign gated[g] = tap_in[g] && (tap_sel == SEL_W'(g));
    end

    assign hit = |gated;
endmodule

// File: rtl/baud_frac_phase.sv
module baud_frac_phase #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] frac_k,
    output logic             carry
);
    localparam logic [DIV_W:0] FULL = {1'b1, {DIV_W{1'b0}}};

    logic [DIV_W-1:0] acc;
    logic [DIV_W:0]   step;
    logic [DIV_W:0]   sum;

    always_comb begin
        step  = FULL - {1'b0, frac_k};
        sum   = {1'b0, acc} + step;
        carry = sum[DIV_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (adv) begin
            acc <= sum[DIV_W-1:0];
        end
    end

    // R5: the phase moves only at a period end
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(acc));
endmodule

// File: rtl/baud_div_fsm.sv
module baud_div_fsm
    import baud_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] div_int,
    input  logic             frac_en,
    input  logic             carry,
    output logic             phase_adv,
    output logic             gen_tick
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    div_state_t       state, state_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic             tick_n;
    logic [DIV_W-1:0] last;
    logic             frac_on;
    logic             at_end;

    always_comb begin
        last    = div_int - ONE;
        frac_on = frac_en && (div_int != ONE);
        at_end  = (state == S_COUNT) && (cnt == last);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_COUNT;
            cnt      <= '0;
            gen_tick <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            gen_tick <= tick_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        tick_n    = 1'b0;
        phase_adv = 1'b0;
        if (cfg_wr) begin
            state_n = S_COUNT;
            cnt_n   = '0;
        end else if (hit) begin
            unique case (state)
                S_COUNT: begin
                    if (at_end) begin
                        cnt_n     = '0;
                        phase_adv = frac_on;
                        if (frac_on && carry) begin
                            state_n = S_EXTRA;
                        end else begin
                            tick_n = 1'b1;
                        end
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                S_EXTRA: begin
                    state_n = S_COUNT;
                    tick_n  = 1'b1;
                end
                default: state_n = S_COUNT;
            endcase
        end
    end

    // R10: a restart is never followed by an output
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !gen_tick);

    // R2: every output is caused by a selected tap
    tap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_tick |-> $past(hit));

    // R6: the extra state is never entered without an active fraction
    extra_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXTRA) |-> $past(frac_on));
endmodule

// File: rtl/baud_out_stage.sv
module baud_out_stage #(
    parameter int OS_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic gen_tick,
    input  logic sync_mode,
    output logic tick16,
    output logic bit_tick,
    output logic sclk
);
    logic [OS_W-1:0] os_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt <= '0;
            sclk   <= 1'b0;
        end else if (cfg_wr) begin
            os_cnt <= '0;
            sclk   <= 1'b0;
        end else if (gen_tick) begin
            os_cnt <= os_cnt + 1'b1;
            if (sync_mode) begin
                sclk <= ~sclk;
            end
        end
    end

    always_comb begin
        tick16   = gen_tick && !sync_mode;
        bit_tick = tick16 && (&os_cnt);
    end

    // R8: a bit tick is always also an oversampling tick
    bit_in_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> tick16);

    // R9: the shift clock moves only after an output in synchronous mode, or on restart
    sclk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> (($past(gen_tick) && $past(sync_mode)) || $past(cfg_wr)));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int SEL_W = 2,
    parameter int DIV_W = 4,
    parameter int OS_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SEL_W)-1:0] tap_in,
    input  logic [SEL_W-1:0]      tap_sel,
    input  logic [DIV_W-1:0]      div_int,
    input  logic [DIV_W-1:0]      frac_k,
    input  logic                  frac_en,
    input  logic                  sync_mode,
    input  logic                  cfg_wr,
    output logic                  tick16,
    output logic                  bit_tick,
    output logic                  sclk
);
    logic hit;
    logic carry;
    logic phase_adv;
    logic gen_tick;

    baud_tap_sel #(.SEL_W(SEL_W)) u_sel (
        .tap_in  (tap_in),
        .tap_sel (tap_sel),
        .hit     (hit)
    );

    baud_frac_phase #(.DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_wr),
        .adv    (phase_adv),
        .frac_k (frac_k),
        .carry  (carry)
    );

    baud_div_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .cfg_wr    (cfg_wr),
        .div_int   (div_int),
        .frac_en   (frac_en),
        .carry     (carry),
        .phase_adv (phase_adv),
        .gen_tick  (gen_tick)
    );

    baud_out_stage #(.OS_W(OS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .gen_tick  (gen_tick),
        .sync_mode (sync_mode),
        .tick16    (tick16),
        .bit_tick  (bit_tick),
        .sclk      (sclk)
    );
endmodule

// File: tb/baud_frac_gen_test.sv
`timescale 1ns/1ps
module baud_frac_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tap_in;
    logic [1:0] tap_sel = '0;
    logic [3:0] div_int = '0;
    logic [3:0] frac_k = '0;
    logic       frac_en = 1'b0;
    logic       sync_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       tick16, bit_tick, sclk;
    logic [2:0] fc = '0;

    int n_chk = 0;
    int n_bad = 0;
    int w_ticks, w_bits, w_tog, w_first, w_second;

    always #2.5 clk = ~clk;

    always @(negedge clk) fc <= fc + 3'd1;
    assign tap_in = {fc == 3'd0, fc[1:0] == 2'd0, fc[0] == 1'b0, 1'b1};

    baud_frac_gen uut (
        .clk(clk), .rst_n(rst_n), .tap_in(tap_in), .tap_sel(tap_sel),
        .div_int(div_int), .frac_k(frac_k), .frac_en(frac_en),
        .sync_mode(sync_mode), .cfg_wr(cfg_wr),
        .tick16(tick16), .bit_tick(bit_tick), .sclk(sclk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [1:0] s, input logic [3:0] n, input logic [3:0] k,
                           input logic fe, input logic sm);
        @(negedge clk);
        tap_sel = s; div_int = n; frac_k = k; frac_en = fe; sync_mode = sm;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic window(input int w);
        logic prev;
        prev = sclk;
        w_ticks = 0; w_bits = 0; w_tog = 0; w_first = -1; w_second = -1;
        for (int i = 1; i <= w; i++) begin
            @(negedge clk);
            if (tick16) begin
                w_ticks++;
                if (w_first < 0) w_first = i;
                else if (w_second < 0) w_second = i;
            end
            if (bit_tick) w_bits++;
            if (sclk != prev) w_tog++;
            prev = sclk;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tick16 == 1'b0, "R1 tick16", tick16, 0);
        check(bit_tick == 1'b0, "R1 bit_tick", bit_tick, 0);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick16 == 1'b0 && sclk == 1'b0, "R1 after release", tick16, 0);
    endtask

    task automatic t_integer();
        restart(2'd0, 4'd3, 4'd0, 1'b0, 1'b0);
        window(48);
        check(w_ticks == 16, "R3 N=3 ticks", w_ticks, 16);
        check(w_first == 3, "R3 N=3 first", w_first, 3);
        restart(2'd0, 4'd0, 4'd0, 1'b0, 1'b0);
        window(160);
        check(w_ticks == 10, "R3 N=0 as 16", w_ticks, 10);
    endtask

    task automatic t_select();
        restart(2'd1, 4'd2, 4'd0, 1'b0, 1'b0);
        window(64);
        check(w_ticks == 16, "R2 tap1 N=2", w_ticks, 16);
        restart(2'd2, 4'd2, 4'd0, 1'b0, 1'b0);
        window(64);
        check(w_ticks == 8, "R2 tap2 N=2", w_ticks, 8);
        restart(2'd3, 4'd1, 4'd0, 1'b0, 1'b0);
        window(64);
        check(w_ticks == 8, "R2 tap3 N=1", w_ticks, 8);
    endtask

    task automatic t_fraction();
        restart(2'd0, 4'd4, 4'd8, 1'b1, 1'b0);
        window(72);
        check(w_ticks == 16, "R4 N=4 K=8 ticks", w_ticks, 16);
        check(w_first == 4, "R5 K=8 first period", w_first, 4);
        check(w_second == 9, "R5 K=8 second period", w_second, 9);
        check(w_bits == 1, "R8 bit tick count", w_bits, 1);
        restart(2'd0, 4'd4, 4'd0, 1'b1, 1'b0);
        window(80);
        check(w_ticks == 16, "R4 K=0 all stretched", w_ticks, 16);
        check(w_first == 5, "R4 K=0 first", w_first, 5);
        restart(2'd0, 4'd4, 4'd15, 1'b1, 1'b0);
        window(65);
        check(w_ticks == 16, "R5 K=15 one stretch", w_ticks, 16);
        check(w_second == 8, "R5 K=15 early unstretched", w_second, 8);
    endtask

    task automatic t_ignored();
        restart(2'd0, 4'd4, 4'd8, 1'b0, 1'b0);
        window(64);
        check(w_ticks == 16, "R7 frac off K ignored", w_ticks, 16);
        check(w_second == 8, "R7 frac off spacing", w_second, 8);
        restart(2'd0, 4'd1, 4'd8, 1'b1, 1'b0);
        window(48);
        check(w_ticks == 48, "R6 N=1 integer only", w_ticks, 48);
    endtask

    task automatic t_uart_bits();
        restart(2'd0, 4'd2, 4'd0, 1'b0, 1'b0);
        window(64);
        check(w_ticks == 32, "R8 tick16 count", w_ticks, 32);
        check(w_bits == 2, "R8 bit_tick count", w_bits, 2);
        check(w_tog == 0, "R8 sclk idle", w_tog, 0);
    endtask

    task automatic t_sync();
        restart(2'd0, 4'd2, 4'd0, 1'b0, 1'b1);
        window(33);
        check(w_tog == 16, "R9 sclk toggles", w_tog, 16);
        check(w_ticks == 0, "R9 tick16 quiet", w_ticks, 0);
        check(w_bits == 0, "R9 bit_tick quiet", w_bits, 0);
    endtask

    task automatic t_collision();
        restart(2'd0, 4'd3, 4'd0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(tick16 == 1'b0, "R10 restart wins", tick16, 0);
        window(3);
        check(w_first == 3, "R10 full period after", w_first, 3);
        restart(2'd0, 4'd2, 4'd0, 1'b0, 1'b1);
        window(3);
        restart(2'd0, 4'd2, 4'd0, 1'b0, 1'b1);
        check(sclk == 1'b0, "R10 sclk cleared", sclk, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_integer();
        t_select();
        t_fraction();
        t_ignored();
        t_uart_bits();
        t_sync();
        t_collision();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule